// File: doc/BRIEF.md
# Coordinate Pixel Plot Unit

This block draws into a small internal bitmap one pixel per clock. The caller loads a screen position into an X/Y coordinate pair, sets a colour byte and a shading mode, and then raises a plot strobe. The unit forms the pixel address from the coordinates itself. It picks the pixel value from the colour register according to the mode: direct, checkerboard dither, or palette-nibble expansion. It then queues the write and steps X forward by one. Successive strobes on successive cycles draw a horizontal run with no further loads.

Each strobe is taken in the cycle it is raised. The write itself lands one cycle later, from a commit stage controlled by a two-state write engine. Its states are IDLE and COMMIT. The transition IDLE→COMMIT fires on an in-bounds strobe. COMMIT→COMMIT fires on an in-bounds strobe while a write is retiring. COMMIT→IDLE fires when no in-bounds strobe arrives. A strobe whose position lies off the screen leaves the engine in IDLE or sends it there, and X still advances. A synchronous read port returns any stored pixel one cycle after it is requested.

Top module: `pixplot_unit`

## Requirements
- R1: After reset X and Y are 0, the colour register is 0, the mode is direct (code 0), and every bitmap location reads back 0.
- R2: An in-bounds plot stores its pixel at address Y*32+X (32x16 screen, 8 bits per pixel). A read requested with `rd_en` returns the stored byte on `rd_data` after the next rising edge.
- R3: Each plot with no coordinate load makes X equal to the old X plus one, modulo 256, and leaves Y unchanged.
- R4: Plots on consecutive cycles are each stored. No strobe is lost or merged.
- R5: In mode code 0 or 3 (direct) the stored byte equals the colour register.
- R6: In mode code 1 (dither), the stored byte is {4'h0, colour[7:4]} when bit 0 of (X xor Y) is 1. Otherwise it is {4'h0, colour[3:0]}.
- R7: In mode code 2 (palette), the stored byte is {colour[7:4], `plot_nib`}. In every other mode `plot_nib` has no effect.
- R8: A plot with X ≥ 32 or Y ≥ 16 changes no bitmap location, but X still advances.
- R9: When `ld_xy` and `plot` are high on the same edge, the plot uses the coordinates held before that edge. Afterwards X and Y equal the loaded values, with no increment.
- R10: When a colour or mode load coincides with a plot, the plot uses the colour and mode held before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| ld_xy | input | 1 | Load both coordinates |
| ld_x_val | input | 8 | X value to load |
| ld_y_val | input | 8 | Y value to load |
| ld_col | input | 1 | Load the colour register |
| col_val | input | 8 | Colour value to load |
| ld_mode | input | 1 | Load the shading mode |
| mode_val | input | 2 | Mode: 0 direct, 1 dither, 2 palette, 3 direct |
| plot | input | 1 | Plot strobe, one pixel per cycle |
| plot_nib | input | 4 | Low nibble used in palette mode |
| rd_en | input | 1 | Bitmap read request |
| rd_addr | input | 9 | Bitmap read address (Y*32+X) |
| rd_data | output | 8 | Read data, valid after the next edge |
| cur_x | output | 8 | Current X coordinate |
| cur_y | output | 8 | Current Y coordinate |

## Verification
A coordinate load and a plot strobe can occur on the same edge, and so can a colour or mode load and a strobe. The bench raises these pairs together on one edge. It then checks that the pixel lands at the old position with the old shading, and that the coordinates take the loaded values rather than the incremented ones. The bench also sweeps every mode over whole rows of back-to-back strobes, runs past the right edge and below the bottom edge, and wraps X through 255. Afterwards it reads the full bitmap and compares it with a model computed in the bench.

// File: rtl/pixplot_pkg.sv
package pixplot_pkg;
    typedef enum logic [1:0] {
        MD_DIRECT  = 2'd0,
        MD_DITHER  = 2'd1,
        MD_PALETTE = 2'd2,
        MD_DIRECT3 = 2'd3
    } shade_mode_t;

    typedef enum logic {
        WS_IDLE   = 1'b0,
        WS_COMMIT = 1'b1
    } wr_state_t;
endpackage

// File: rtl/pixplot_coord.sv
module pixplot_coord #(
    parameter int COORD_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               ld_xy,
    input  logic [COORD_W-1:0] ld_x,
    input  logic [COORD_W-1:0] ld_y,
    input  logic               step,
    output logic [COORD_W-1:0] x,
    output logic [COORD_W-1:0] y
);
    localparam logic [COORD_W-1:0] ONE = COORD_W'(1);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            x <= '0;
            y <= '0;
        end else if (ld_xy) begin
            x <= ld_x;
            y <= ld_y;
        end else if (step) begin
            x <= x + ONE;
        end
    end

    AST_X_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !ld_xy) |=> (x == $past(x) + ONE)); // R3
    AST_Y_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !ld_xy) |=> $stable(y)); // R3
    AST_LOAD_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        ld_xy |=> (x == $past(ld_x) && y == $past(ld_y))); // R9
endmodule

// File: rtl/pixplot_shade.sv
module pixplot_shade
    import pixplot_pkg::*;
#(
    parameter int PIX_W = 8
) (
    input  shade_mode_t      mode,
    input  logic [PIX_W-1:0] colour,
    input  logic [3:0]       nib,
    input  logic             odd_cell,
    output logic [PIX_W-1:0] pix
);
    localparam int HALF = PIX_W / 2;

    always_comb begin
        unique case (mode)
            MD_DITHER:  pix = odd_cell ? PIX_W'(colour[PIX_W-1:HALF])
                                       : PIX_W'(colour[HALF-1:0]);
            MD_PALETTE: pix = {colour[PIX_W-1:HALF], HALF'(nib)};
            MD_DIRECT,
            MD_DIRECT3: pix = colour;
            default:    pix = colour;
        endcase
    end

    always_comb begin
        if (mode == MD_DITHER)
            AST_DITHER_HIGH_ZERO: assert (pix[PIX_W-1:HALF] == '0); // R6
    end
endmodule

// File: rtl/pixplot_store.sv
module pixplot_store
    import pixplot_pkg::*;
#(
    parameter int PIX_W  = 8,
    parameter int DEPTH  = 512,
    parameter int ADDR_W = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_req,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [PIX_W-1:0]  wr_data,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [PIX_W-1:0]  rd_data,
    output logic              commit_v,
    output logic [ADDR_W-1:0] commit_addr
);
    wr_state_t         st, st_nx;
    logic [PIX_W-1:0]  commit_data;
    logic [PIX_W-1:0]  mem [DEPTH];

    always_comb begin
        st_nx = st;
        unique case (st)
            WS_IDLE:   st_nx = wr_req ? WS_COMMIT : WS_IDLE;
            WS_COMMIT: st_nx = wr_req ? WS_COMMIT : WS_IDLE;
            default:   st_nx = WS_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st <= WS_IDLE;
        else        st <= st_nx;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            commit_addr <= '0;
            commit_data <= '0;
        end else if (wr_req) begin
            commit_addr <= wr_addr;
            commit_data <= wr_data;
        end
    end

    assign commit_v = (st == WS_COMMIT);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else if (commit_v) begin
            mem[commit_addr] <= commit_data;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)     rd_data <= '0;
        else if (rd_en) rd_data <= mem[rd_addr];
    end

    AST_EVERY_REQ_COMMITS: assert property (@(posedge clk) disable iff (!rst_n)
        wr_req |=> commit_v); // R4
    AST_NO_REQ_NO_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_req |=> !commit_v); // R8
endmodule

// File: rtl/pixplot_unit.sv
module pixplot_unit
    import pixplot_pkg::*;
#(
    parameter int COORD_W = 8,
    parameter int SCR_W   = 32,
    parameter int SCR_H   = 16,
    parameter int PIX_W   = 8,
    localparam int DEPTH  = SCR_W * SCR_H,
    localparam int ADDR_W = $clog2(DEPTH)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               ld_xy,
    input  logic [COORD_W-1:0] ld_x_val,
    input  logic [COORD_W-1:0] ld_y_val,
    input  logic               ld_col,
    input  logic [PIX_W-1:0]   col_val,
    input  logic               ld_mode,
    input  logic [1:0]         mode_val,
    input  logic               plot,
    input  logic [3:0]         plot_nib,
    input  logic               rd_en,
    input  logic [ADDR_W-1:0]  rd_addr,
    output logic [PIX_W-1:0]   rd_data,
    output logic [COORD_W-1:0] cur_x,
    output logic [COORD_W-1:0] cur_y
);
    localparam logic [COORD_W:0] W_LIM = (COORD_W+1)'(SCR_W);
    localparam logic [COORD_W:0] H_LIM = (COORD_W+1)'(SCR_H);

    logic [COORD_W-1:0] rx, ry;
    logic [PIX_W-1:0]   colour_q, pix;
    shade_mode_t        mode_q;
    logic               in_bounds, wr_req, commit_v;
    logic [ADDR_W-1:0]  pix_addr, commit_addr;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            colour_q <= '0;
            mode_q   <= MD_DIRECT;
        end else begin
            if (ld_col)  colour_q <= col_val;
            if (ld_mode) mode_q   <= shade_mode_t'(mode_val);
        end
    end

    pixplot_coord #(.COORD_W(COORD_W)) coord_i (
        .clk(clk), .rst_n(rst_n), .ld_xy(ld_xy),
        .ld_x(ld_x_val), .ld_y(ld_y_val), .step(plot),
        .x(rx), .y(ry)
    );

    assign in_bounds = ({1'b0, rx} < W_LIM) && ({1'b0, ry} < H_LIM);
    assign pix_addr  = ADDR_W'(int'(ry) * SCR_W + int'(rx));
    assign wr_req    = plot && in_bounds;

    pixplot_shade #(.PIX_W(PIX_W)) shade_i (
        .mode(mode_q), .colour(colour_q), .nib(plot_nib),
        .odd_cell(rx[0] ^ ry[0]), .pix(pix)
    );

    pixplot_store #(.PIX_W(PIX_W), .DEPTH(DEPTH), .ADDR_W(ADDR_W)) store_i (
        .clk(clk), .rst_n(rst_n), .wr_req(wr_req),
        .wr_addr(pix_addr), .wr_data(pix),
        .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
        .commit_v(commit_v), .commit_addr(commit_addr)
    );

    assign cur_x = rx;
    assign cur_y = ry;

    AST_OOB_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (plot && !in_bounds) |=> !commit_v); // R8
    AST_COMMIT_AT_COORD: assert property (@(posedge clk) disable iff (!rst_n)
        (plot && in_bounds) |=> (commit_v &&
            commit_addr == ADDR_W'(int'($past(ry)) * SCR_W + int'($past(rx))))); // R2
endmodule

// File: tb/pixplot_unit_tb_top.sv
module pixplot_unit_tb_top;
    localparam int CLK_PER = 10;

    logic       clk = 0, rst_n = 0;
    logic       ld_xy = 0, ld_col = 0, ld_mode = 0, plot = 0, rd_en = 0;
    logic [7:0] ld_x_val = 0, ld_y_val = 0, col_val = 0;
    logic [1:0] mode_val = 0;
    logic [3:0] plot_nib = 0;
    logic [8:0] rd_addr = 0;
    logic [7:0] rd_data, cur_x, cur_y;

    int checks = 0, errors = 0;
    bit done = 0;

    logic [7:0] refm [512];
    logic [7:0] mx = 0, my = 0, mcol = 0;
    logic [1:0] mmode = 0;

    always #(CLK_PER/2) clk = ~clk;

    pixplot_unit dut_i (
        .clk(clk), .rst_n(rst_n), .ld_xy(ld_xy), .ld_x_val(ld_x_val),
        .ld_y_val(ld_y_val), .ld_col(ld_col), .col_val(col_val),
        .ld_mode(ld_mode), .mode_val(mode_val), .plot(plot),
        .plot_nib(plot_nib), .rd_en(rd_en), .rd_addr(rd_addr),
        .rd_data(rd_data), .cur_x(cur_x), .cur_y(cur_y)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] shade(input logic [1:0] m, input logic [7:0] c,
                                         input logic [3:0] n, input logic odd);
        case (m)
            2'd1:    return odd ? {4'h0, c[7:4]} : {4'h0, c[3:0]};
            2'd2:    return {c[7:4], n};
            default: return c;
        endcase
    endfunction

    // One edge with the given controls; model updated from pre-edge state.
    task automatic step(input bit p, input logic [3:0] n,
                        input bit lxy, input logic [7:0] lx, input logic [7:0] ly,
                        input bit lc, input logic [7:0] c,
                        input bit lm, input logic [1:0] m, input string req);
        plot = p; plot_nib = n; ld_xy = lxy; ld_x_val = lx; ld_y_val = ly;
        ld_col = lc; col_val = c; ld_mode = lm; mode_val = m;
        @(posedge clk);
        if (p && mx < 32 && my < 16)
            refm[{my[3:0], mx[4:0]}] = shade(mmode, mcol, n, mx[0] ^ my[0]);
        if (lxy) begin mx = lx; my = ly; end
        else if (p) mx = mx + 8'd1;
        if (lc) mcol = c;
        if (lm) mmode = m;
        @(negedge clk);
        plot = 0; ld_xy = 0; ld_col = 0; ld_mode = 0;
        check(cur_x == mx, req, cur_x, mx);
        check(cur_y == my, req, cur_y, my);
    endtask

    task automatic idle();
        @(posedge clk); @(negedge clk);
    endtask

    task automatic dump(input string req);
        for (int a = 0; a < 512; a++) begin
            rd_en = 1; rd_addr = 9'(a);
            @(posedge clk); @(negedge clk);
            check(rd_data == refm[a], req, rd_data, refm[a]);
        end
        rd_en = 0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        for (int a = 0; a < 512; a++) refm[a] = 8'h00;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1: reset state
        check(cur_x == 0, "R1", cur_x, 0);
        check(cur_y == 0, "R1", cur_y, 0);
        dump("R1");

        // R5 R4 R3 R8: direct mode rows, back-to-back, running off right edge
        for (int r = 0; r < 16; r++) begin
            step(0, 0, 1, 0, 8'(r), 1, 8'(r * 16 + 3), r == 0, 2'd0, "R5");
            for (int k = 0; k < 36; k++)
                step(1, 4'(k), 0, 0, 0, 0, 0, 0, 0, k < 32 ? "R4" : "R8");
        end
        idle();
        dump("R5");

        // R6: dither over the top half, R3 also checked per step
        step(0, 0, 0, 0, 0, 1, 8'hA5, 1, 2'd1, "R6");
        for (int r = 0; r < 8; r++) begin
            step(0, 0, 1, 0, 8'(r), 0, 0, 0, 0, "R6");
            for (int k = 0; k < 32; k++) step(1, 4'(15 - k), 0, 0, 0, 0, 0, 0, 0, "R6");
        end
        // R7: palette over the bottom half
        step(0, 0, 0, 0, 0, 1, 8'hC7, 1, 2'd2, "R7");
        for (int r = 8; r < 16; r++) begin
            step(0, 0, 1, 0, 8'(r), 0, 0, 0, 0, "R7");
            for (int k = 0; k < 32; k++) step(1, 4'(k ^ r), 0, 0, 0, 0, 0, 0, 0, "R7");
        end
        // mode 3 behaves as direct (R5)
        step(0, 0, 1, 8'd10, 8'd3, 1, 8'h5E, 1, 2'd3, "R5");
        step(1, 4'h9, 0, 0, 0, 0, 0, 0, 0, "R5");
        idle();
        dump("R7");

        // R3: X wraps 255 -> 0, then writes at x=0
        step(0, 0, 1, 8'd254, 8'd2, 1, 8'h3C, 1, 2'd0, "R3");
        for (int k = 0; k < 3; k++) step(1, 0, 0, 0, 0, 0, 0, 0, 0, "R3");
        check(cur_x == 8'd1, "R3", cur_x, 1);
        // R8: Y out of range writes nothing
        step(0, 0, 1, 8'd5, 8'd16, 1, 8'hEE, 0, 0, "R8");
        for (int k = 0; k < 4; k++) step(1, 0, 0, 0, 0, 0, 0, 0, 0, "R8");
        // R9: coordinate load on the same edge as a plot
        step(0, 0, 1, 8'd3, 8'd4, 1, 8'h77, 0, 0, "R9");
        step(1, 4'h1, 1, 8'd7, 8'd9, 0, 0, 0, 0, "R9");
        check(cur_x == 8'd7 && cur_y == 8'd9, "R9", {cur_y, cur_x}, 16'h0907);
        step(1, 4'h2, 1, 8'd20, 8'd12, 0, 0, 0, 0, "R9");
        // R10: colour and mode load on the same edge as a plot
        step(1, 4'h6, 0, 0, 0, 1, 8'h91, 1, 2'd2, "R10");
        step(1, 4'h6, 0, 0, 0, 1, 8'h2B, 1, 2'd1, "R10");
        step(1, 4'h6, 0, 0, 0, 0, 0, 0, 0, "R10");
        idle();
        dump("R2");

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule